// File: doc/BRIEF.md
# Endpoint DMA Handshake Handler

This block sits between one USB device-side endpoint byte buffer and an external DMA controller. Software writes a small configuration register that names the endpoint to service, the direction of flow, the channel wiring and an arm bit. While armed, the block holds a request line high whenever the buffer can take part in a transfer. It moves exactly one byte for each acknowledge it receives while that request is high.

A transfer ends in one of two ways: a terminal-count strobe from the DMA controller, or software writing the arm bit to 0. Either way the buffer is emptied within one clock, whatever it still held, and the arm bit drops. Software must arm the block again before the next transfer. A wiring bit chooses which of two request/acknowledge pin pairs carries the handshake. The pair that is not chosen has its request held low and its acknowledge ignored.

The USB side fills the buffer when the DMA controller reads from it, and drains the buffer when the DMA controller writes into it. The buffer accepts bytes from the USB side even while the block is not armed.

Top module: `epdma_hs_top`

## Requirements
- R1: After reset the configuration reads back as 0 and both request outputs are low.
- R2: The configuration word is 7 bits wide and reads back as written when the write is accepted. Bits [3:0] are the endpoint index, bit 4 is the arm bit, bit 5 selects single-channel wiring, and bit 6 sets the direction (1 = DMA reads from the buffer, 0 = DMA writes into it).
- R3: A write with bit 4 set and an index of 0 or 15 is rejected: the register keeps its previous contents and no request is raised.
- R4: In read direction an armed block holds the request high while the buffer holds at least one byte. Each acknowledge takes the oldest byte, which is shown on `dma_rdata` while the request is high. The request drops in the cycle after the acknowledge that takes the last byte.
- R5: In write direction an armed block holds the request high while the buffer has at least one free byte. Each acknowledge stores `dma_wdata`. The USB side reads the bytes back in arrival order. The request drops in the cycle after the acknowledge that fills the buffer, and it rises again once the USB side frees a byte.
- R6: A `dma_eot` pulse while armed clears the arm bit, empties the buffer and drops the request, all in the next cycle. Bytes that were not read are discarded.
- R7: A write with bit 4 = 0 empties the buffer and drops the request in the next cycle.
- R8: After a termination, no request is raised until the arm bit is written to 1 again, even if the buffer receives data.
- R9: With bit 5 = 0 the handshake uses `ch2_req`/`ch2_ack`; `ch1_req` stays low and `ch1_ack` is ignored. With bit 5 = 1 the handshake uses `ch1_req`/`ch1_ack`; `ch2_req` stays low and `ch2_ack` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Configuration write value |
| cfg_rdata | output | 7 | Current configuration |
| dma_eot | input | 1 | Terminal-count strobe from the DMA controller |
| ch1_req | output | 1 | Request on the first channel pair |
| ch1_ack | input | 1 | Acknowledge on the first channel pair |
| ch2_req | output | 1 | Request on the second channel pair |
| ch2_ack | input | 1 | Acknowledge on the second channel pair |
| dma_wdata | input | DATA_W | Byte written by the DMA controller |
| dma_rdata | output | DATA_W | Oldest buffered byte, read by the DMA controller |
| usb_wr_en | input | 1 | USB side writes a byte (read direction only) |
| usb_wr_data | input | DATA_W | Byte from the USB side |
| usb_rd_en | input | 1 | USB side takes a byte (write direction only) |
| usb_rd_data | output | DATA_W | Oldest buffered byte for the USB side |

## Verification
The hardest case to reach from the ports is showing that a termination really discards unread bytes. After the flush, the bytes that were thrown away leave no trace on any output. The stimulus loads three bytes and lets the DMA take one. It then strobes terminal count and loads one fresh byte while the block is disarmed, which also shows that no request appears. After re-arming, exactly the fresh byte must come out, and the request must drop after that single acknowledge. In write direction the check is made by a count instead: after a software stop and re-arm, five acknowledges must leave the request still high. That could not happen if the three earlier bytes had stayed in the buffer.

// File: rtl/epdma_pkg.sv
package epdma_pkg;

    localparam int IDX_W = 4;

    // Configuration word; bit order is what software sees
    typedef struct packed {
        logic             dir_rd;     // 1: DMA reads from the buffer
        logic             single_ch;  // 1: handshake on channel 1 pins
        logic             enable;     // arm bit
        logic [IDX_W-1:0] ep_idx;     // endpoint index
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    localparam logic [IDX_W-1:0] EP_FIRST_DMA = IDX_W'(1);
    localparam logic [IDX_W-1:0] EP_LAST_DMA  = IDX_W'(14);

    typedef enum logic [1:0] {
        HS_OFF  = 2'd0,
        HS_IDLE = 2'd1,
        HS_REQ  = 2'd2
    } hs_state_e;

endpackage

// File: rtl/epdma_cfg_reg.sv
module epdma_cfg_reg
    import epdma_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             eot,
    output cfg_t             cfg_q,
    output cfg_t             cfg_d,
    output logic             flush
);

    cfg_t wr_cfg;
    logic idx_ok;
    logic accept;
    logic eot_hit;

    always_comb begin
        wr_cfg  = cfg_t'(wr_data);
        idx_ok  = (wr_cfg.ep_idx >= EP_FIRST_DMA) && (wr_cfg.ep_idx <= EP_LAST_DMA);
        accept  = wr_en && (!wr_cfg.enable || idx_ok);
        eot_hit = eot && cfg_q.enable;
        flush   = (wr_en && !wr_cfg.enable) || eot_hit;

        cfg_d = cfg_q;
        if (accept) begin
            cfg_d = wr_cfg;
        end
        if (eot_hit) begin
            cfg_d.enable = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

endmodule

// File: rtl/epdma_byte_buf.sv
module epdma_byte_buf #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              flush,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  cnt_d
);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] cnt;
    } buf_st_t;

    buf_st_t s_q, s_d;
    logic [DATA_W-1:0] mem [DEPTH];
    logic do_push;
    logic do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        do_push = push && (s_q.cnt != CNT_W'(DEPTH)) && !flush;
        do_pop  = pop && (s_q.cnt != '0) && !flush;

        s_d = s_q;
        if (flush) begin
            s_d = '0;
        end else begin
            if (do_push) begin
                s_d.wr_ptr = ptr_next(s_q.wr_ptr);
            end
            if (do_pop) begin
                s_d.rd_ptr = ptr_next(s_q.rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   s_d.cnt = s_q.cnt + CNT_W'(1);
                2'b01:   s_d.cnt = s_q.cnt - CNT_W'(1);
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[s_q.wr_ptr] <= push_data;
        end
    end

    assign head  = mem[s_q.rd_ptr];
    assign cnt_q = s_q.cnt;
    assign cnt_d = s_d.cnt;

endmodule

// File: rtl/epdma_hs_fsm.sv
module epdma_hs_fsm
    import epdma_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_d,
    input  logic             dir_rd_d,
    input  logic [CNT_W-1:0] cnt_d,
    input  logic             ack,
    output logic             req,
    output logic             xfer
);

    hs_state_e state_q, state_d;
    logic can_move;

    always_comb begin
        can_move = dir_rd_d ? (cnt_d != '0) : (cnt_d != CNT_W'(DEPTH));
        if (!en_d) begin
            state_d = HS_OFF;
        end else if (can_move) begin
            state_d = HS_REQ;
        end else begin
            state_d = HS_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HS_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    assign req  = (state_q == HS_REQ);
    assign xfer = req && ack;

endmodule

// File: rtl/epdma_pin_route.sv
module epdma_pin_route (
    input  logic single_ch,
    input  logic req,
    input  logic ch1_ack,
    input  logic ch2_ack,
    output logic ch1_req,
    output logic ch2_req,
    output logic ack
);

    always_comb begin
        ch1_req = single_ch && req;
        ch2_req = !single_ch && req;
        ack     = single_ch ? ch1_ack : ch2_ack;
    end

endmodule

// File: rtl/epdma_hs_top.sv
module epdma_hs_top
    import epdma_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              dma_eot,
    output logic              ch1_req,
    input  logic              ch1_ack,
    output logic              ch2_req,
    input  logic              ch2_ack,
    input  logic [DATA_W-1:0] dma_wdata,
    output logic [DATA_W-1:0] dma_rdata,
    input  logic              usb_wr_en,
    input  logic [DATA_W-1:0] usb_wr_data,
    input  logic              usb_rd_en,
    output logic [DATA_W-1:0] usb_rd_data
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    cfg_t              cfg_q, cfg_d;
    logic              flush;
    logic              hs_req;
    logic              hs_ack;
    logic              xfer;
    logic              buf_push;
    logic              buf_pop;
    logic [DATA_W-1:0] buf_wdata;
    logic [DATA_W-1:0] buf_head;
    logic [CNT_W-1:0]  buf_cnt_q;
    logic [CNT_W-1:0]  buf_cnt_d;

    epdma_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .eot     (dma_eot),
        .cfg_q   (cfg_q),
        .cfg_d   (cfg_d),
        .flush   (flush)
    );

    // Direction decides which side fills and which side drains
    always_comb begin
        if (cfg_q.dir_rd) begin
            buf_push  = usb_wr_en;
            buf_wdata = usb_wr_data;
            buf_pop   = xfer;
        end else begin
            buf_push  = xfer;
            buf_wdata = dma_wdata;
            buf_pop   = usb_rd_en;
        end
    end

    epdma_byte_buf #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (buf_push),
        .push_data (buf_wdata),
        .pop       (buf_pop),
        .flush     (flush),
        .head      (buf_head),
        .cnt_q     (buf_cnt_q),
        .cnt_d     (buf_cnt_d)
    );

    epdma_hs_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_d     (cfg_d.enable),
        .dir_rd_d (cfg_d.dir_rd),
        .cnt_d    (buf_cnt_d),
        .ack      (hs_ack),
        .req      (hs_req),
        .xfer     (xfer)
    );

    epdma_pin_route u_route (
        .single_ch (cfg_q.single_ch),
        .req       (hs_req),
        .ch1_ack   (ch1_ack),
        .ch2_ack   (ch2_ack),
        .ch1_req   (ch1_req),
        .ch2_req   (ch2_req),
        .ack       (hs_ack)
    );

    assign cfg_rdata   = cfg_q;
    assign dma_rdata   = buf_head;
    assign usb_rd_data = buf_head;

endmodule

// File: rtl/epdma_hs_chk.sv
module epdma_hs_chk #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [6:0]       cfg_wdata,
    input logic [6:0]       cfg_rdata,
    input logic             dma_eot,
    input logic             ch1_req,
    input logic             ch1_ack,
    input logic             ch2_req,
    input logic             ch2_ack,
    input logic             usb_wr_en,
    input logic             usb_rd_en,
    input logic [CNT_W-1:0] buf_cnt
);

    logic any_req;
    logic eff_ack;
    logic bad_arm;

    assign any_req = ch1_req || ch2_req;
    assign eff_ack = cfg_rdata[5] ? ch1_ack : ch2_ack;
    assign bad_arm = cfg_we && cfg_wdata[4] &&
                     ((cfg_wdata[3:0] == 4'd0) || (cfg_wdata[3:0] == 4'd15));

    // R3: a request only ever appears for a DMA-capable index
    p_idx_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |-> (cfg_rdata[4] && cfg_rdata[3:0] != 4'd0 && cfg_rdata[3:0] != 4'd15));

    // R3: arming with index 0 or 15 leaves the register untouched
    p_reject_bad_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_arm && !dma_eot) |=> $stable(cfg_rdata));

    // R4: request falls after the acknowledge that takes the last byte
    p_last_byte_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (any_req && eff_ack && cfg_rdata[6] && buf_cnt == CNT_W'(1) &&
         !usb_wr_en && !dma_eot && !cfg_we) |=> !any_req);

    // R5: request falls after the acknowledge that fills the buffer
    p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (any_req && eff_ack && !cfg_rdata[6] && buf_cnt == CNT_W'(DEPTH - 1) &&
         !usb_rd_en && !dma_eot && !cfg_we) |=> !any_req);

    // R6: terminal count disarms and empties
    p_eot_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_eot && cfg_rdata[4]) |=> (!cfg_rdata[4] && buf_cnt == '0 && !any_req));

    // R7: software stop empties the buffer
    p_sw_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_wdata[4]) |=> (buf_cnt == '0 && !any_req));

    // R9: unused pair keeps its request low
    p_ch1_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[5] |-> !ch1_req);
    p_ch2_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[5] |-> !ch2_req);

endmodule

bind epdma_hs_top epdma_hs_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .dma_eot   (dma_eot),
    .ch1_req   (ch1_req),
    .ch1_ack   (ch1_ack),
    .ch2_req   (ch2_req),
    .ch2_ack   (ch2_ack),
    .usb_wr_en (usb_wr_en),
    .usb_rd_en (usb_rd_en),
    .buf_cnt   (buf_cnt_q)
);

// File: tb/tb_epdma_hs_top.sv
`timescale 1ns/1ps
module tb_epdma_hs_top;

    localparam int DEPTH = 8;
    localparam int DW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [6:0]    cfg_wdata = '0;
    logic [6:0]    cfg_rdata;
    logic          dma_eot = 1'b0;
    logic          ch1_req, ch2_req;
    logic          ch1_ack = 1'b0, ch2_ack = 1'b0;
    logic [DW-1:0] dma_wdata = '0, dma_rdata;
    logic          usb_wr_en = 1'b0, usb_rd_en = 1'b0;
    logic [DW-1:0] usb_wr_data = '0, usb_rd_data;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] q_in[$];
    logic [DW-1:0] q_out[$];
    bit mode_single = 1'b0;
    bit mode_in = 1'b0;

    always #2.5 clk = ~clk;

    epdma_hs_top #(.DEPTH(DEPTH), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .dma_eot(dma_eot), .ch1_req(ch1_req),
        .ch1_ack(ch1_ack), .ch2_req(ch2_req), .ch2_ack(ch2_ack),
        .dma_wdata(dma_wdata), .dma_rdata(dma_rdata), .usb_wr_en(usb_wr_en),
        .usb_wr_data(usb_wr_data), .usb_rd_en(usb_rd_en), .usb_rd_data(usb_rd_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic eff_req();
        return mode_single ? ch1_req : ch2_req;
    endfunction

    function automatic logic eff_ack();
        return mode_single ? ch1_ack : ch2_ack;
    endfunction

    // Monitor: pops expected bytes as the design hands them out
    always @(negedge clk) begin
        if (rst_n) begin
            if (mode_in && eff_req() && eff_ack() && !dma_eot && !cfg_we) begin
                if (q_in.size() == 0) begin
                    chk(1'b0, "R4 unexpected DMA read byte", dma_rdata, 0);
                end else begin
                    logic [DW-1:0] e;
                    e = q_in.pop_front();
                    chk(dma_rdata == e, "R4 DMA read byte", dma_rdata, e);
                end
            end
            if (!mode_in && usb_rd_en) begin
                if (q_out.size() != 0) begin
                    logic [DW-1:0] e;
                    e = q_out.pop_front();
                    chk(usb_rd_data == e, "R5 USB read byte", usb_rd_data, e);
                end
            end
        end
    end

    task automatic cfg_write(input logic [6:0] v);
        @(posedge clk); #1;
        cfg_we = 1'b1;
        cfg_wdata = v;
        if (!(v[4] && (v[3:0] == 4'd0 || v[3:0] == 4'd15))) begin
            mode_single = v[5];
            mode_in = v[6];
        end
        if (!v[4]) begin
            q_in.delete();
            q_out.delete();
        end
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic usb_push(input logic [DW-1:0] b);
        @(posedge clk); #1;
        usb_wr_en = 1'b1;
        usb_wr_data = b;
        q_in.push_back(b);
        @(posedge clk); #1;
        usb_wr_en = 1'b0;
    endtask

    task automatic dma_ack(input int n, input logic [DW-1:0] base);
        @(posedge clk); #1;
        for (int i = 0; i < n; i++) begin
            dma_wdata = base + DW'(i);
            if (!mode_in) q_out.push_back(base + DW'(i));
            if (mode_single) ch1_ack = 1'b1; else ch2_ack = 1'b1;
            @(posedge clk); #1;
        end
        ch1_ack = 1'b0;
        ch2_ack = 1'b0;
    endtask

    task automatic usb_read(input int n);
        @(posedge clk); #1;
        usb_rd_en = 1'b1;
        repeat (n) begin
            @(posedge clk); #1;
        end
        usb_rd_en = 1'b0;
    endtask

    task automatic pulse_eot();
        @(posedge clk); #1;
        dma_eot = 1'b1;
        q_in.delete();
        q_out.delete();
        @(posedge clk); #1;
        dma_eot = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cfg_rdata == 7'h00, "R1 cfg after reset", cfg_rdata, 7'h00);
        chk(!ch1_req && !ch2_req, "R1 requests after reset", {ch1_req, ch2_req}, 0);

        // R3 arming with index 0 / 15 from the disarmed state
        cfg_write(7'h10);
        @(negedge clk);
        chk(cfg_rdata == 7'h00, "R3 index 0 rejected", cfg_rdata, 7'h00);
        chk(!ch1_req && !ch2_req, "R3 no request idx 0", {ch1_req, ch2_req}, 0);
        cfg_write(7'h1F);
        @(negedge clk);
        chk(cfg_rdata == 7'h00, "R3 index 15 rejected", cfg_rdata, 7'h00);

        // R2 field layout read back
        cfg_write(7'h43);
        @(negedge clk);
        chk(cfg_rdata == 7'h43, "R2 readback disarmed", cfg_rdata, 7'h43);
        cfg_write(7'h53);
        @(negedge clk);
        chk(cfg_rdata == 7'h53, "R2 readback armed", cfg_rdata, 7'h53);
        chk(!ch2_req, "R4 no request on empty buffer", ch2_req, 0);

        // R3 rejection while armed
        cfg_write(7'h5F);
        @(negedge clk);
        chk(cfg_rdata == 7'h53, "R3 armed register kept", cfg_rdata, 7'h53);

        // R4 read direction on channel 2
        usb_push(8'hA1);
        usb_push(8'hA2);
        usb_push(8'hA3);
        @(negedge clk);
        chk(ch2_req, "R4 request with data", ch2_req, 1);
        chk(!ch1_req, "R9 channel 1 idle", ch1_req, 0);
        dma_ack(2, 8'h00);
        @(negedge clk);
        chk(ch2_req, "R4 request held with one byte left", ch2_req, 1);
        dma_ack(1, 8'h00);
        @(negedge clk);
        chk(!ch2_req, "R4 request drop after last byte", ch2_req, 0);

        // R9 single-channel wiring
        cfg_write(7'h73);
        usb_push(8'hB1);
        @(negedge clk);
        chk(ch1_req && !ch2_req, "R9 handshake on channel 1", {ch1_req, ch2_req}, 2'b10);
        @(posedge clk); #1 ch2_ack = 1'b1;
        @(posedge clk); #1 ch2_ack = 1'b0;
        @(negedge clk);
        chk(ch1_req, "R9 channel 2 ack ignored", ch1_req, 1);
        dma_ack(1, 8'h00);
        @(negedge clk);
        chk(!ch1_req, "R9 channel 1 ack consumed byte", ch1_req, 0);

        // R6 / R8 termination by strobe, flush, re-arm
        usb_push(8'hC1);
        usb_push(8'hC2);
        usb_push(8'hC3);
        dma_ack(1, 8'h00);
        pulse_eot();
        @(negedge clk);
        chk(cfg_rdata == 7'h63, "R6 arm bit cleared", cfg_rdata, 7'h63);
        chk(!ch1_req, "R6 request dropped", ch1_req, 0);
        usb_push(8'hD1);
        @(negedge clk);
        chk(!ch1_req && !ch2_req, "R8 no request before re-arm", {ch1_req, ch2_req}, 0);
        cfg_write(7'h73);
        @(negedge clk);
        chk(ch1_req, "R8 request after re-arm", ch1_req, 1);
        dma_ack(1, 8'h00);
        @(negedge clk);
        chk(!ch1_req, "R6 unread bytes discarded", ch1_req, 0);
        chk(q_in.size() == 0, "R6 fresh byte delivered", q_in.size(), 0);

        // R5 write direction, fill to the brim then drain
        cfg_write(7'h15);
        @(negedge clk);
        chk(ch2_req && !ch1_req, "R5 request with free space", {ch1_req, ch2_req}, 2'b01);
        dma_ack(8, 8'h30);
        @(negedge clk);
        chk(!ch2_req, "R5 request drop when full", ch2_req, 0);
        usb_read(1);
        @(negedge clk);
        chk(ch2_req, "R5 request back after USB read", ch2_req, 1);
        usb_read(7);
        @(negedge clk);
        chk(q_out.size() == 0, "R5 all bytes read in order", q_out.size(), 0);

        // R7 software stop flushes partly filled buffer
        dma_ack(3, 8'h50);
        cfg_write(7'h05);
        @(negedge clk);
        chk(cfg_rdata == 7'h05 && !ch2_req, "R7 stop clears arm and request",
            {cfg_rdata, ch2_req}, {7'h05, 1'b0});
        cfg_write(7'h15);
        dma_ack(5, 8'h60);
        @(negedge clk);
        chk(ch2_req, "R7 buffer was emptied by stop", ch2_req, 1);
        pulse_eot();
        @(negedge clk);
        chk(!ch2_req && !cfg_rdata[4], "R6 strobe in write direction",
            {cfg_rdata[4], ch2_req}, 0);

        finish_run();
    end

endmodule